// File: doc/BRIEF.md
# GPIO Port with Read-Snapshot Change Interrupt

This block is a six-position general-purpose I/O port on a simple register bus. Five positions (0, 1, 2, 4, 5) are bidirectional. Position 3 is input-only and never drives. A direction register decides, for each pin, whether the pin is an input or an output. An output latch holds the levels that output pins drive. The pin register returns the live, synchronized pin levels when read, and a write to it lands in the output latch. A separate latch address returns the latched value, so software can do read-modify-write sequences on the outputs without picking up pin levels.

Change detection does not compare a pin against its value on the previous clock. Each pin is compared against a snapshot that is taken whenever the pin register is read. A pin takes part only when it is an input, when its own change-enable bit is set and when the global change enable is on. The per-pin mismatches are ORed together. The result drives a small two-state machine, with states CHG_IDLE and CHG_PEND, that holds the change flag:
- CHG_IDLE goes to CHG_PEND when any qualified mismatch is present and no clear is written in that cycle.
- CHG_PEND goes back to CHG_IDLE when software writes 0 to the flag bit.

The usual service routine reads the pin register, which refreshes the snapshot, and then clears the flag.

Register addresses (3-bit `addr_i`):
- 0: pins (read: synchronized levels; write: output latch)
- 1: direction
- 2: latch
- 3: change enables
- 4: control (bit 0 is the global enable, bit 1 is the change flag)
- 5 to 7: unused

Top module: `gpio_chg_port`

## Requirements
- R1: After reset, direction reads 0x3F (all inputs), and latch, change enables and control read 0x00. `pin_oe_o` is 0 and `chg_flag_o` is 0.
- R2: For positions 0, 1, 2, 4 and 5, `pin_oe_o` bit is the inverse of the direction bit (1 = input, 0 = output) and `pin_o` bit is the latch bit. Position 3 never drives (`pin_oe_o[3]` and `pin_o[3]` are always 0).
- R3: A read of address 0 returns, on `rdata_o` in the cycle after `rd_en_i`, the pin levels after a two-flop synchronizer. A pin change is therefore visible to a read issued 3 cycles after the change.
- R4: A write to address 0 or address 2 updates the output latch. A read of address 2 returns the latch, not the pin levels.
- R5: When an enabled input pin differs from the snapshot and the global enable is set, `chg_flag_o` rises one cycle after the synchronized mismatch appears.
- R6: With control bit 0 (global enable) clear, no pin change sets the flag.
- R7: A pin whose change-enable bit (address 3, bit = pin position) is 0, or whose direction bit is 0 (output), is excluded from change detection.
- R8: The flag is sticky. It stays set after the pin returns to the snapshot value. Writing 1 to control bit 1 has no effect. Writing 0 clears it. If the mismatch persists, it sets again in the cycle after the clear.
- R9: Every read of address 0 loads the snapshot with the synchronized pins, so a following clear leaves the flag at 0.
- R10: Bits 7:6 of every register read as 0 and writes to them are ignored. Direction bit 3 is fixed at 1. Latch bit 3 reads 0. Addresses 5 to 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data, valid the cycle after `rd_en_i` |
| pin_i | input | 6 | Pin levels (asynchronous) |
| pin_o | output | 6 | Driven pin values |
| pin_oe_o | output | 6 | Per-pin output enable |
| chg_flag_o | output | 1 | Combined change flag |

## Verification
The assertions check, on every cycle:
- that the flag stays set until a clear write arrives;
- that it cannot set while the global enable is off;
- that a clear always takes the flag low;
- that output enables and driven values follow direction and latch writes;
- that a pin-register read loads the snapshot.

Only the bench scenarios can show the rest:
- the synchronizer latency;
- the exclusion of output pins and disabled pins;
- the re-set after a clear when a mismatch persists;
- the refresh-then-clear service sequence;
- the handling of unused bits and addresses.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
    localparam int ADDR_W    = 3;
    localparam int CTRL_GIE  = 0;
    localparam int CTRL_FLAG = 1;

    typedef enum logic [ADDR_W-1:0] {
        A_PINS = 3'd0,
        A_DIR  = 3'd1,
        A_LAT  = 3'd2,
        A_CEN  = 3'd3,
        A_CTRL = 3'd4
    } reg_addr_e;

    typedef enum logic {
        CHG_IDLE = 1'b0,
        CHG_PEND = 1'b1
    } chg_state_e;
endpackage

// File: rtl/gpio_chg_sync.sv
module gpio_chg_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_chg_regs.sv
module gpio_chg_regs
    import gpio_chg_pkg::*;
#(
    parameter int              DATA_W   = 8,
    parameter int              PIN_W    = 6,
    parameter logic [PIN_W-1:0] DRV_MASK = 6'b110111
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [PIN_W-1:0]  pin_s_i,
    input  logic              flag_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [PIN_W-1:0]  dir_o,
    output logic [PIN_W-1:0]  lat_o,
    output logic [PIN_W-1:0]  cen_o,
    output logic              gie_o,
    output logic              flag_clr_o,
    output logic              snap_load_o
);
    localparam int PAD_W = DATA_W - PIN_W;

    logic [PIN_W-1:0]  dir_q, lat_q, cen_q;
    logic              gie_q;
    logic [DATA_W-1:0] rd_mux, rdata_q;
    logic [PIN_W-1:0]  wd_pins;
    logic              unused_wbits;

    assign wd_pins      = wdata_i[PIN_W-1:0];
    assign unused_wbits = ^wdata_i[DATA_W-1:PIN_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dir_q <= '1;
            lat_q <= '0;
            cen_q <= '0;
            gie_q <= 1'b0;
        end else if (wr_en_i) begin
            case (addr_i)
                A_PINS, A_LAT: lat_q <= wd_pins & DRV_MASK;
                A_DIR:         dir_q <= wd_pins | ~DRV_MASK;
                A_CEN:         cen_q <= wd_pins;
                A_CTRL:        gie_q <= wdata_i[CTRL_GIE];
                default:       ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        case (addr_i)
            A_PINS:  rd_mux = {{PAD_W{1'b0}}, pin_s_i};
            A_DIR:   rd_mux = {{PAD_W{1'b0}}, dir_q};
            A_LAT:   rd_mux = {{PAD_W{1'b0}}, lat_q};
            A_CEN:   rd_mux = {{PAD_W{1'b0}}, cen_q};
            A_CTRL: begin
                rd_mux[CTRL_GIE]  = gie_q;
                rd_mux[CTRL_FLAG] = flag_i;
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      rdata_q <= '0;
        else if (rd_en_i) rdata_q <= rd_mux;
    end

    assign rdata_o     = rdata_q;
    assign dir_o       = dir_q;
    assign lat_o       = lat_q;
    assign cen_o       = cen_q;
    assign gie_o       = gie_q;
    assign flag_clr_o  = wr_en_i && (addr_i == A_CTRL) && !wdata_i[CTRL_FLAG];
    assign snap_load_o = rd_en_i && (addr_i == A_PINS);
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect
    import gpio_chg_pkg::*;
#(
    parameter int PIN_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [PIN_W-1:0] pin_s_i,
    input  logic [PIN_W-1:0] dir_i,
    input  logic [PIN_W-1:0] cen_i,
    input  logic             gie_i,
    input  logic             snap_load_i,
    input  logic             flag_clr_i,
    output logic [PIN_W-1:0] snap_o,
    output logic [PIN_W-1:0] mism_o,
    output logic             flag_o
);
    logic [PIN_W-1:0] snap_q;
    chg_state_e       state_q, state_d;
    logic             any_mism;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          snap_q <= '0;
        else if (snap_load_i) snap_q <= pin_s_i;
    end

    assign mism_o   = (pin_s_i ^ snap_q) & cen_i & dir_i & {PIN_W{gie_i}};
    assign any_mism = |mism_o;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= CHG_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CHG_IDLE: if (!flag_clr_i && any_mism) state_d = CHG_PEND;
            CHG_PEND: if (flag_clr_i)              state_d = CHG_IDLE;
        endcase
    end

    always_comb begin
        flag_o = (state_q == CHG_PEND);
    end

    assign snap_o = snap_q;
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
    import gpio_chg_pkg::*;
#(
    parameter int               DATA_W      = 8,
    parameter int               PIN_W       = 6,
    parameter int               SYNC_STAGES = 2,
    parameter logic [PIN_W-1:0] DRV_MASK    = 6'b110111
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [PIN_W-1:0]  pin_i,
    output logic [PIN_W-1:0]  pin_o,
    output logic [PIN_W-1:0]  pin_oe_o,
    output logic              chg_flag_o
);
    logic [PIN_W-1:0] pin_s, dir_q, lat_q, cen_q, snap_q, mism;
    logic             gie_q, flag_clr, snap_load, flag;

    gpio_chg_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_s)
    );

    gpio_chg_regs #(.DATA_W(DATA_W), .PIN_W(PIN_W), .DRV_MASK(DRV_MASK)) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .rd_en_i(rd_en_i), .wdata_i(wdata_i), .pin_s_i(pin_s), .flag_i(flag),
        .rdata_o(rdata_o), .dir_o(dir_q), .lat_o(lat_q), .cen_o(cen_q),
        .gie_o(gie_q), .flag_clr_o(flag_clr), .snap_load_o(snap_load)
    );

    gpio_chg_detect #(.PIN_W(PIN_W)) u_detect (
        .clk_i(clk_i), .rst_ni(rst_ni), .pin_s_i(pin_s), .dir_i(dir_q),
        .cen_i(cen_q), .gie_i(gie_q), .snap_load_i(snap_load),
        .flag_clr_i(flag_clr), .snap_o(snap_q), .mism_o(mism), .flag_o(flag)
    );

    for (genvar b = 0; b < PIN_W; b++) begin : g_drv
        if (DRV_MASK[b]) begin : g_bidir
            assign pin_o[b]    = lat_q[b];
            assign pin_oe_o[b] = ~dir_q[b];
        end else begin : g_inonly
            assign pin_o[b]    = 1'b0;
            assign pin_oe_o[b] = 1'b0;
        end
    end

    assign chg_flag_o = flag;
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk
    import gpio_chg_pkg::*;
#(
    parameter int               DATA_W   = 8,
    parameter int               PIN_W    = 6,
    parameter logic [PIN_W-1:0] DRV_MASK = 6'b110111
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [PIN_W-1:0]  pin_o,
    input logic [PIN_W-1:0]  pin_oe_o,
    input logic              chg_flag_o,
    input logic [PIN_W-1:0]  pin_s,
    input logic [PIN_W-1:0]  snap_q,
    input logic              gie_q
);
    logic clr_wr;
    assign clr_wr = wr_en_i && (addr_i == A_CTRL) && !wdata_i[CTRL_FLAG];

    // R8: flag holds until a clear write
    p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chg_flag_o && !clr_wr) |=> chg_flag_o);

    // R8: a clear write always drops the flag
    p_flag_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_wr |=> !chg_flag_o);

    // R6: global enable off means no new flag
    p_gie_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!chg_flag_o && !gie_q) |=> !chg_flag_o);

    // R2: output enables follow a direction write
    p_dir_drive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == A_DIR) |=>
            (pin_oe_o == (~$past(wdata_i[PIN_W-1:0]) & DRV_MASK)));

    // R4: driven values follow a latch or pin-register write
    p_latch_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (addr_i == A_LAT || addr_i == A_PINS)) |=>
            (pin_o == ($past(wdata_i[PIN_W-1:0]) & DRV_MASK)));

    // R9: a pin-register read captures the synchronized pins
    p_snap_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && addr_i == A_PINS) |=> (snap_q == $past(pin_s)));
endmodule

bind gpio_chg_port gpio_chg_port_chk #(
    .DATA_W(DATA_W), .PIN_W(PIN_W), .DRV_MASK(DRV_MASK)
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .wdata_i(wdata_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
    .chg_flag_o(chg_flag_o), .pin_s(pin_s), .snap_q(snap_q), .gie_q(gie_q)
);

// File: tb/test_gpio_chg_port.sv
module test_gpio_chg_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [5:0] pin_in = '0;
    logic [5:0] pin_out, pin_oe;
    logic       flag;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    typedef struct { logic [7:0] exp; string tag; } item_t;
    item_t sb_q[$];
    logic  rd_seen = 1'b0;

    always #5 clk = ~clk;

    gpio_chg_port i_gpio_chg_port (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
        .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in),
        .pin_o(pin_out), .pin_oe_o(pin_oe), .chg_flag_o(flag)
    );

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: note the read strobe at the edge, compare half a cycle later
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            item_t it;
            if (sb_q.size() == 0) begin
                chk(rdata, 8'hxx, "scoreboard underflow");
            end else begin
                it = sb_q.pop_front();
                chk(rdata, it.exp, it.tag);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk({2'b0, pin_oe}, 8'h00, "R1 oe after reset");
        chk({7'b0, flag}, 8'h00, "R1 flag after reset");
        rd(3'd1, 8'h3F, "R1 dir reset");
        rd(3'd2, 8'h00, "R1 latch reset");
        rd(3'd3, 8'h00, "R1 cen reset");
        rd(3'd4, 8'h00, "R1 ctrl reset");

        // R2 / R10 direction and drive
        wr(3'd1, 8'h00);
        chk({2'b0, pin_oe}, 8'h37, "R2 oe all outputs, pos3 never");
        rd(3'd1, 8'h08, "R10 dir bit3 fixed");
        wr(3'd2, 8'hFF);
        chk({2'b0, pin_out}, 8'h37, "R2 pin_o from latch");
        rd(3'd2, 8'h37, "R10 latch unused bits");
        // R4 write via pin register, latch read independent of pins
        wr(3'd0, 8'h15);
        chk({2'b0, pin_out}, 8'h15, "R4 pin-register write to latch");
        pin_in = 6'h2A;
        idle(3);
        rd(3'd2, 8'h15, "R4 latch read not pins");
        // R3 pin read through synchronizer
        rd(3'd0, 8'h2A, "R3 pin levels");
        pin_in = 6'h00;
        idle(3);
        rd(3'd0, 8'h00, "R3 pin levels low");
        // R10 unused bits and addresses
        wr(3'd3, 8'hFF);
        rd(3'd3, 8'h3F, "R10 cen upper bits");
        rd(3'd5, 8'h00, "R10 unused address");

        // change detection setup: all inputs, all enabled
        wr(3'd1, 8'h3F);
        rd(3'd0, 8'h00, "R9 snapshot read");
        wr(3'd4, 8'h01);
        idle(3);
        chk({7'b0, flag}, 8'h00, "R5 no change yet");
        // R5 input-only pin changes
        pin_in = 6'h08;
        idle(4);
        chk({7'b0, flag}, 8'h01, "R5 flag on change");
        // R8 sticky
        pin_in = 6'h00;
        idle(4);
        chk({7'b0, flag}, 8'h01, "R8 sticky after return");
        wr(3'd4, 8'h03);
        chk({7'b0, flag}, 8'h01, "R8 writing 1 no effect");
        wr(3'd4, 8'h01);
        chk({7'b0, flag}, 8'h00, "R8 cleared by 0");
        idle(3);
        chk({7'b0, flag}, 8'h00, "R8 stays clear, no mismatch");
        // R8 re-set while mismatch persists
        pin_in = 6'h01;
        idle(4);
        chk({7'b0, flag}, 8'h01, "R5 flag pin0");
        wr(3'd4, 8'h01);
        idle(1);
        chk({7'b0, flag}, 8'h01, "R8 re-sets with persistent mismatch");
        // R9 refresh then clear
        rd(3'd0, 8'h01, "R9 refresh read");
        wr(3'd4, 8'h01);
        idle(3);
        chk({7'b0, flag}, 8'h00, "R9 clear holds after refresh");
        rd(3'd4, 8'h01, "R8 ctrl readback");

        // R7 per-pin enable off
        wr(3'd3, 8'h3E);
        pin_in = 6'h00;
        idle(4);
        chk({7'b0, flag}, 8'h00, "R7 disabled pin ignored");
        rd(3'd0, 8'h00, "R9 resnapshot");
        wr(3'd3, 8'h3F);
        // R7 output pin excluded
        wr(3'd1, 8'h3E);
        pin_in = 6'h01;
        idle(4);
        chk({7'b0, flag}, 8'h00, "R7 output pin ignored");
        rd(3'd0, 8'h01, "R9 resnapshot out");
        wr(3'd1, 8'h3F);
        idle(2);
        chk({7'b0, flag}, 8'h00, "R7 restore no flag");

        // R6 global enable off
        wr(3'd4, 8'h00);
        pin_in = 6'h21;
        idle(4);
        chk({7'b0, flag}, 8'h00, "R6 gated off");
        rd(3'd4, 8'h00, "R6 ctrl readback");

        idle(3);
        chk(8'(sb_q.size()), 8'h00, "scoreboard drained");
        finish_run();
    end
endmodule